// File: doc/BRIEF.md
# Wavetable Oscillator with Selectable Interpolation

A digital oscillator that walks a 256-entry single-cycle waveform table with a 32-bit phase accumulator. A precomputed increment sets the pitch. The increment equals table length times output frequency divided by sample rate. Its top 8 bits are a table step and its low 24 bits are a fraction. Each sample-rate strobe produces one signed 16-bit output sample, together with a one-cycle valid pulse.

Four waveforms are built in: sine, triangle, square and sawtooth. Three read-out methods are chosen at run time: truncation, rounding to the nearest entry, and linear interpolation between neighbouring entries. The increment may be changed on any strobe without disturbing the phase, which lets an exponential pitch control drive it directly.

Top module: `wt_osc`

## Requirements
- R1: While rst_ni is low, sample_vld_o is 0 and the phase is zero, so the first sample after reset reads table entry 0.
- R2: On every strobe the phase becomes (phase + phase_inc_i) mod 2^32, and the sample for that strobe uses the phase from before the addition. Without a strobe the phase holds.
- R3: sample_vld_o is high for exactly one cycle, two cycles after each cycle with sample_stb_i high. The mode does not change this latency. Back-to-back strobes give back-to-back valid cycles.
- R4: interp_sel_i = 0 (truncate) or 3 outputs the entry at index phase[31:24].
- R5: interp_sel_i = 1 (round) outputs the entry at (phase[31:24] + phase[23]) mod 256.
- R6: interp_sel_i = 2 (linear) outputs a + floor((b - a) * f / 256). Here a is the entry at phase[31:24], b is the entry at (phase[31:24] + 1) mod 256, and f is phase[23:16].
- R7: wave_sel_i = 0 (sine): entry i = round(32767 * sin(2*pi*i/256)), with halves rounded away from zero.
- R8: wave_sel_i = 1 (triangle): entry i = (i - 64) * 512 for i < 128, and (191 - i) * 512 otherwise.
- R9: wave_sel_i = 2 (square): entry i = +32767 for i < 128 and -32767 otherwise.
- R10: wave_sel_i = 3 (sawtooth): entry i = (i - 128) * 256.
- R11: wave_sel_i and interp_sel_i are sampled only in the strobe cycle. Changing them between strobes has no effect on the next output sample.
- R12: Changing phase_inc_i between strobes never resets the phase. The accumulation simply continues with the new step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_stb_i | input | 1 | Sample-rate strobe, one cycle per sample |
| phase_inc_i | input | 32 | Phase increment: 8-bit integer step, 24-bit fraction |
| wave_sel_i | input | 2 | Waveform: 0 sine, 1 triangle, 2 square, 3 sawtooth |
| interp_sel_i | input | 2 | Read-out: 0 truncate, 1 round, 2 linear, 3 truncate |
| sample_o | output | 16 | Signed output sample |
| sample_vld_o | output | 1 | One-cycle pulse marking a new sample |

## Verification
The bench builds the block with its default parameters: a 32-bit phase, an 8-bit index, 16-bit samples and an 8-bit interpolation weight. At those widths a step of exactly one entry per strobe sweeps all 256 entries of every table and crosses the 255-to-0 wrap. Half-entry steps toggle phase bit 23 on alternate strobes, which drives the rounding carry across the wrap. Odd fractional steps spread the linear weight over its whole 0..255 range, with negative differences on falling edges of each waveform. Selects are scrambled between strobes and the increment is varied mid-run, so the sampling and continuity rules are observed at the output.

// File: rtl/wt_osc_pkg.sv
package wt_osc_pkg;
  typedef enum logic [1:0] {
    WAVE_SINE   = 2'd0,
    WAVE_TRI    = 2'd1,
    WAVE_SQUARE = 2'd2,
    WAVE_SAW    = 2'd3
  } wave_e;

  typedef enum logic [1:0] {
    MODE_TRUNC  = 2'd0,
    MODE_ROUND  = 2'd1,
    MODE_LINEAR = 2'd2,
    MODE_RSVD   = 2'd3
  } interp_e;
endpackage

// File: rtl/wt_phase_addr.sv
module wt_phase_addr
  import wt_osc_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int IDX_W   = 8,
  parameter int FRAC_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               stb_i,
  input  logic [PHASE_W-1:0] inc_i,
  input  wave_e              wave_i,
  input  interp_e            mode_i,
  output logic               vld_o,
  output logic [IDX_W-1:0]   idx_a_o,
  output logic [IDX_W-1:0]   idx_b_o,
  output logic [FRAC_W-1:0]  frac_o,
  output wave_e              wave_o,
  output logic               lin_o
);
  localparam int RND_BIT = PHASE_W - IDX_W - 1;

  logic [PHASE_W-1:0] phase_q;
  logic [IDX_W-1:0]   idx_base;
  logic [IDX_W-1:0]   idx_sel;

  assign idx_base = phase_q[PHASE_W-1 -: IDX_W];

  always_comb begin
    idx_sel = idx_base;
    if (mode_i == MODE_ROUND) idx_sel = idx_base + IDX_W'(phase_q[RND_BIT]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      vld_o   <= 1'b0;
      idx_a_o <= '0;
      idx_b_o <= '0;
      frac_o  <= '0;
      wave_o  <= WAVE_SINE;
      lin_o   <= 1'b0;
    end else begin
      vld_o <= stb_i;
      if (stb_i) begin
        phase_q <= phase_q + inc_i;
        idx_a_o <= idx_sel;
        idx_b_o <= idx_base + IDX_W'(1);
        frac_o  <= phase_q[RND_BIT -: FRAC_W];
        wave_o  <= wave_i;
        lin_o   <= (mode_i == MODE_LINEAR);
      end
    end
  end

  // R2
  phase_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i |=> phase_q == $past(phase_q) + $past(inc_i));

  // R2
  phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> $stable(phase_q));

  // R3
  stage1_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i |=> vld_o);
endmodule

// File: rtl/wt_wave_lut.sv
module wt_wave_lut
  import wt_osc_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int SAMPLE_W = 16
) (
  input  logic [IDX_W-1:0]           idx_i,
  input  wave_e                      wave_i,
  output logic signed [SAMPLE_W-1:0] smp_o
);
  localparam int DEPTH     = 1 << IDX_W;
  localparam int AMP       = (1 << (SAMPLE_W - 1)) - 1;
  localparam int TRI_SCALE = 1 << (SAMPLE_W - IDX_W + 1);
  localparam int SAW_PAD   = SAMPLE_W - IDX_W;

  function automatic logic [DEPTH*SAMPLE_W-1:0] build_sine();
    logic [DEPTH*SAMPLE_W-1:0] t;
    real r;
    int  v;
    t = '0;
    for (int i = 0; i < DEPTH; i++) begin
      r = $sin(2.0 * 3.14159265358979 * real'(i) / real'(DEPTH)) * real'(AMP);
      v = (r >= 0.0) ? $rtoi(r + 0.5) : $rtoi(r - 0.5);
      t[i*SAMPLE_W +: SAMPLE_W] = SAMPLE_W'(v);
    end
    return t;
  endfunction

  localparam logic [DEPTH*SAMPLE_W-1:0] SINE_LUT = build_sine();

  int tri_v;

  always_comb begin
    if (!idx_i[IDX_W-1]) tri_v = (int'(idx_i) - DEPTH / 4) * TRI_SCALE;
    else                 tri_v = (3 * DEPTH / 4 - 1 - int'(idx_i)) * TRI_SCALE;
  end

  always_comb begin
    unique case (wave_i)
      WAVE_SINE:   smp_o = SINE_LUT[int'(idx_i)*SAMPLE_W +: SAMPLE_W];
      WAVE_TRI:    smp_o = SAMPLE_W'(tri_v);
      WAVE_SQUARE: smp_o = idx_i[IDX_W-1] ? SAMPLE_W'(-AMP) : SAMPLE_W'(AMP);
      default:     smp_o = {~idx_i[IDX_W-1], idx_i[IDX_W-2:0], {SAW_PAD{1'b0}}};
    endcase
  end
endmodule

// File: rtl/wt_interp.sv
module wt_interp #(
  parameter int SAMPLE_W = 16,
  parameter int FRAC_W   = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       vld_i,
  input  logic                       lin_i,
  input  logic signed [SAMPLE_W-1:0] a_i,
  input  logic signed [SAMPLE_W-1:0] b_i,
  input  logic [FRAC_W-1:0]          frac_i,
  output logic                       vld_o,
  output logic signed [SAMPLE_W-1:0] smp_o
);
  localparam int DW = SAMPLE_W + 1;
  localparam int PW = SAMPLE_W + FRAC_W + 2;

  logic signed [DW-1:0]       diff;
  logic signed [PW-1:0]       prod;
  logic signed [PW-1:0]       step;
  logic signed [SAMPLE_W-1:0] lin_val;

  assign diff    = DW'(b_i) - DW'(a_i);
  assign prod    = PW'(diff) * PW'($signed({1'b0, frac_i}));
  assign step    = prod >>> FRAC_W;
  assign lin_val = a_i + SAMPLE_W'(step);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      smp_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) smp_o <= lin_i ? lin_val : a_i;
    end
  end

  // R6
  always_ff @(posedge clk_i) begin
    if (rst_ni && vld_i && lin_i) begin
      interp_bound_chk: assert ((lin_val >= a_i && lin_val <= b_i) ||
                                (lin_val <= a_i && lin_val >= b_i));
    end
  end

  // R3
  out_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> vld_o);

  // R3
  out_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> !vld_o);
endmodule

// File: rtl/wt_osc.sv
module wt_osc
  import wt_osc_pkg::*;
#(
  parameter int PHASE_W  = 32,
  parameter int IDX_W    = 8,
  parameter int SAMPLE_W = 16,
  parameter int FRAC_W   = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sample_stb_i,
  input  logic [PHASE_W-1:0]         phase_inc_i,
  input  logic [1:0]                 wave_sel_i,
  input  logic [1:0]                 interp_sel_i,
  output logic signed [SAMPLE_W-1:0] sample_o,
  output logic                       sample_vld_o
);
  localparam int N_TAP = 2;

  logic                       s1_vld;
  logic [IDX_W-1:0]           tap_idx [N_TAP];
  logic signed [SAMPLE_W-1:0] tap_smp [N_TAP];
  logic [FRAC_W-1:0]          s1_frac;
  wave_e                      s1_wave;
  logic                       s1_lin;

  wt_phase_addr #(
    .PHASE_W(PHASE_W),
    .IDX_W  (IDX_W),
    .FRAC_W (FRAC_W)
  ) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (sample_stb_i),
    .inc_i  (phase_inc_i),
    .wave_i (wave_e'(wave_sel_i)),
    .mode_i (interp_e'(interp_sel_i)),
    .vld_o  (s1_vld),
    .idx_a_o(tap_idx[0]),
    .idx_b_o(tap_idx[1]),
    .frac_o (s1_frac),
    .wave_o (s1_wave),
    .lin_o  (s1_lin)
  );

  for (genvar g = 0; g < N_TAP; g++) begin : g_tap
    wt_wave_lut #(
      .IDX_W   (IDX_W),
      .SAMPLE_W(SAMPLE_W)
    ) u_lut (
      .idx_i (tap_idx[g]),
      .wave_i(s1_wave),
      .smp_o (tap_smp[g])
    );
  end

  wt_interp #(
    .SAMPLE_W(SAMPLE_W),
    .FRAC_W  (FRAC_W)
  ) u_interp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (s1_vld),
    .lin_i (s1_lin),
    .a_i   (tap_smp[0]),
    .b_i   (tap_smp[1]),
    .frac_i(s1_frac),
    .vld_o (sample_vld_o),
    .smp_o (sample_o)
  );
endmodule

// File: tb/wt_osc_bench.sv
module wt_osc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               stb = 1'b0;
  logic [31:0]        inc = '0;
  logic [1:0]         wave = '0;
  logic [1:0]         mode = '0;
  logic signed [15:0] smp;
  logic               vld;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  string stage = "R1";
  logic [31:0] m_phase = '0;

  typedef struct {
    int    exp;
    int    cyc;
    string tag;
  } item_t;
  item_t sb_q[$];

  wt_osc u_wt_osc (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .sample_stb_i(stb),
    .phase_inc_i (inc),
    .wave_sel_i  (wave),
    .interp_sel_i(mode),
    .sample_o    (smp),
    .sample_vld_o(vld)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int tbl(int i, int wv);
    real r;
    case (wv)
      0: begin
        r = $sin(2.0 * 3.14159265358979 * real'(i) / 256.0) * 32767.0;
        return (r >= 0.0) ? $rtoi(r + 0.5) : $rtoi(r - 0.5);
      end
      1: return (i < 128) ? (i - 64) * 512 : (191 - i) * 512;
      2: return (i < 128) ? 32767 : -32767;
      default: return (i - 128) * 256;
    endcase
  endfunction

  function automatic int model(logic [31:0] ph, int wv, int md);
    int idx, a, b, f, d;
    idx = int'(ph[31:24]);
    if (md == 1) idx = (idx + int'(ph[23])) % 256;
    a = tbl(idx, wv);
    if (md != 2) return a;
    b = tbl((idx + 1) % 256, wv);
    f = int'(ph[23:16]);
    d = (b - a) * f;
    return a + (d >>> 8);
  endfunction

  function automatic string mode_tag(int md);
    case (md)
      1: return "R5";
      2: return "R6";
      default: return "R4";
    endcase
  endfunction

  function automatic string wave_tag(int wv);
    case (wv)
      0: return "R7";
      1: return "R8";
      2: return "R9";
      default: return "R10";
    endcase
  endfunction

  // Called at a negedge; leaves the bench at a negedge.
  task automatic send(input logic [31:0] s_inc, input int wv, input int md, input int gap);
    item_t it;
    stb  = 1'b1;
    inc  = s_inc;
    wave = 2'(wv);
    mode = 2'(md);
    it.exp = model(m_phase, wv, md);
    it.cyc = cyc;
    it.tag = {stage, " ", mode_tag(md), " ", wave_tag(wv)};
    sb_q.push_back(it);
    m_phase = m_phase + s_inc;
    @(negedge clk);
    stb  = 1'b0;
    // R11: scramble selects and increment between strobes
    wave = 2'(wv + 1);
    mode = 2'(md + 1);
    inc  = ~s_inc;
    repeat (gap) @(negedge clk);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && vld) begin
      item_t it;
      checks++;
      if (sb_q.size() == 0) begin
        fails++;
        $display("FAIL R3 unexpected valid: actual=1 expected=0 cyc=%0d", cyc);
      end else begin
        it = sb_q.pop_front();
        if (cyc - it.cyc != 2) begin
          fails++;
          $display("FAIL R3 latency: actual=%0d expected=2", cyc - it.cyc);
        end
        checks++;
        if (int'(smp) != it.exp) begin
          fails++;
          $display("FAIL %s sample: actual=%0d expected=%0d", it.tag, int'(smp), it.exp);
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    checks++;
    if (vld !== 1'b0) begin
      fails++;
      $display("FAIL R1 valid in reset: actual=%b expected=0", vld);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (vld !== 1'b0) begin
      fails++;
      $display("FAIL R1 valid after reset: actual=%b expected=0", vld);
    end

    // R1: first sample reads entry 0
    stage = "R1";
    send(32'h0000_0000, 3, 0, 3);

    // R2 R10: one entry per strobe, full sweep with wrap, back-to-back
    stage = "R2";
    for (int k = 0; k < 260; k++) send(32'h0100_0000, 3, 0, 0);
    send(32'h0100_0000, 3, 0, 4);

    stage = "R7";
    for (int k = 0; k < 90; k++) send(32'h0340_0000, 0, 0, 1);
    stage = "R8";
    for (int k = 0; k < 70; k++) send(32'h0500_0000, 1, 0, 0);
    stage = "R9";
    for (int k = 0; k < 40; k++) send(32'h0900_0000, 2, 0, 2);

    // R5: half-step toggles bit 23, crosses 255->0
    stage = "R5";
    for (int k = 0; k < 520; k++) send(32'h0080_0000, k % 4, 1, 0);

    // R6: odd fraction spreads the weight
    stage = "R6";
    for (int k = 0; k < 300; k++) send(32'h0123_4567, k % 4, 2, k % 3);

    // R4: reserved code behaves as truncation
    stage = "R4";
    for (int k = 0; k < 60; k++) send(32'h02A0_0000, k % 4, 3, 1);

    // R12: increment changes every strobe, phase continues
    stage = "R12";
    for (int k = 0; k < 64; k++) send(32'h0010_0000 << (k % 8), k % 4, k % 3, 0);
    send(32'hFFFF_FF00, 0, 2, 1);
    send(32'hFFFF_0000, 1, 2, 1);

    // R11: selects changed between strobes with long gaps
    stage = "R11";
    for (int k = 0; k < 40; k++) send(32'h0777_7777, (k * 3) % 4, k % 4, 3);

    repeat (6) @(negedge clk);
    checks++;
    if (sb_q.size() != 0) begin
      fails++;
      $display("FAIL R3 missing valid: actual=%0d expected=0 pending", sb_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule